// File: doc/BRIEF.md
# Cache Line Burst Engine

This block sits between a write-back cache and an AXI memory port. It moves whole 64-byte lines in both directions. A miss hands it the byte address of the word the processor is waiting for. The engine then issues a wrapping read of four 16-byte beats. That read starts at the beat holding the wanted word, so this critical word comes back first. Each returned beat goes straight back to the cache, tagged with its beat slot inside the line.

On the write side, the cache hands over a whole line together with its byte strobes and a beat-count code. A full-line eviction goes out as an incrementing burst of four beats from the line base. A read-allocate write of one or two beats is aligned to its own size. Because of that alignment, no write burst runs past the end of the line. Write beats carry the captured data and strobes unchanged, including beats whose strobes are all low. The eviction completes on the write response.

Each direction holds at most one transaction. While a direction is busy, its request ready stays low. The two directions run independently of each other.

Top module: `line_burst_engine`

## Requirements
- R1: A taken linefill request produces, from the next cycle, one read address with length code 3, size code 3'b100 and burst code 2'b10 (wrapping). Its address is the request address with bits [3:0] cleared.
- R2: While a linefill waits for data, r_ready is high. Each accepted R beat appears in the same cycle on fill_beat_valid with data and response unchanged. The n-th beat (n counting from 0) carries fill_beat_idx = (request address bits [5:4] + n) mod 4.
- R3: fill_beat_last is high on the fourth beat only. fill_req_ready is high again in the cycle after that beat.
- R4: Only one linefill is in flight. fill_req_ready and r_ready are low whenever no linefill beat can be taken (fill_req_ready low from the accepting edge until the last beat, r_ready low outside the data phase).
- R5: A write request with beat code 2'b10 or 2'b11 produces a write address at the line base (address bits [5:0] cleared), with length code 3, size code 3'b100 and burst code 2'b01 (incrementing). No burst ever uses burst code 2'b00.
- R6: Beat code 2'b00 produces length 0 at the 16-byte beat of the request address. Beat code 2'b01 produces length 1 with address bit 4 also cleared. No write burst crosses a 64-byte line boundary.
- R7: The k-th write beat carries line slot (start slot + k). Slot j is bits [128*j +: 128] of the line input and bits [16*j +: 16] of the strobe input, and strobes are passed unchanged even when all are low. w_last is high on the final beat only, and the W payload holds while w_ready is low.
- R8: b_ready is high only after the last write beat. evict_done pulses in the cycle the B beat is taken, with evict_resp equal to b_resp. evict_req_ready is high again in the next cycle and low from the accepting edge until then.
- R9: A read or write address, once valid, stays valid with unchanged address and length until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fill_req_valid | input | 1 | Linefill request present |
| fill_req_ready | output | 1 | Linefill request taken when high together with valid |
| fill_req_addr | input | ADDR_W | Byte address of the critical word |
| ar_valid | output | 1 | Read address valid |
| ar_ready | input | 1 | Read address accepted |
| ar_addr | output | ADDR_W | Read burst start address |
| ar_len | output | 8 | Read beats minus one |
| ar_size | output | 3 | Read beat size code |
| ar_burst | output | 2 | Read burst type |
| r_valid | input | 1 | Read data valid |
| r_ready | output | 1 | Read data accepted |
| r_data | input | 128 | Read beat data |
| r_resp | input | 2 | Read beat response |
| fill_beat_valid | output | 1 | A line beat is returned to the cache |
| fill_beat_idx | output | 2 | Slot of the returned beat in the line |
| fill_beat_data | output | 128 | Returned beat data |
| fill_beat_resp | output | 2 | Returned beat response |
| fill_beat_last | output | 1 | Final beat of the linefill |
| evict_req_valid | input | 1 | Write request present |
| evict_req_ready | output | 1 | Write request taken when high together with valid |
| evict_req_addr | input | ADDR_W | Byte address inside the line |
| evict_req_beats | input | 2 | Beat code: 00 one, 01 two, 10 or 11 full line |
| evict_req_line | input | 512 | Line data, slot j at bits [128*j +: 128] |
| evict_req_strb | input | 64 | Byte strobes, slot j at bits [16*j +: 16] |
| aw_valid | output | 1 | Write address valid |
| aw_ready | input | 1 | Write address accepted |
| aw_addr | output | ADDR_W | Write burst start address |
| aw_len | output | 8 | Write beats minus one |
| aw_size | output | 3 | Write beat size code |
| aw_burst | output | 2 | Write burst type |
| w_valid | output | 1 | Write data valid |
| w_ready | input | 1 | Write data accepted |
| w_data | output | 128 | Write beat data |
| w_strb | output | 16 | Write beat strobes |
| w_last | output | 1 | Final write beat |
| b_valid | input | 1 | Write response valid |
| b_ready | output | 1 | Write response accepted |
| b_resp | input | 2 | Write response code |
| evict_done | output | 1 | Write transaction complete |
| evict_resp | output | 2 | Response of the completed write |

## Verification
A read or write address is due in the cycle after its request is taken. It stays due for as many cycles as the bench keeps the matching ready low. A returned fill beat, and the completion pulse, are due in the same cycle as the R or B beat that causes them. Each write beat is due in the cycle after the previous beat was taken, or after the address was taken for the first beat. A request ready comes back in the cycle after the final beat or response. The bench changes inputs on the falling edge and reads outputs 1 ns later, so every check lands in exactly the cycle the requirement names. It sweeps every 4-byte word position in the line, every beat code and several ready stall patterns.

// File: rtl/lbe_pkg.sv
package lbe_pkg;

    localparam int DATA_W     = 128;
    localparam int STRB_W     = DATA_W / 8;
    localparam int LINE_BYTES = 64;
    localparam int LINE_BEATS = LINE_BYTES / STRB_W;
    localparam int BEAT_W     = $clog2(LINE_BEATS);
    localparam int BYTE_W     = $clog2(STRB_W);
    localparam int LINE_W     = $clog2(LINE_BYTES);
    localparam int LINE_DW    = DATA_W * LINE_BEATS;
    localparam int LINE_SW    = STRB_W * LINE_BEATS;

    localparam logic [2:0] SIZE_BEAT = 3'(BYTE_W);

    typedef enum logic [1:0] {
        BURST_FIXED = 2'b00,
        BURST_INCR  = 2'b01,
        BURST_WRAP  = 2'b10
    } burst_e;

    typedef enum logic [1:0] {
        WCNT_ONE  = 2'b00,
        WCNT_TWO  = 2'b01,
        WCNT_FOUR = 2'b10,
        WCNT_LINE = 2'b11
    } wcnt_e;

    typedef enum logic [1:0] {
        RD_IDLE,
        RD_ADDR,
        RD_DATA
    } rd_state_e;

    typedef enum logic [1:0] {
        WR_IDLE,
        WR_ADDR,
        WR_DATA,
        WR_RESP
    } wr_state_e;

    // first slot of a write burst, aligned to the burst's own size
    function automatic logic [BEAT_W-1:0] wr_first_slot(
        input logic [BEAT_W-1:0] slot,
        input wcnt_e             code
    );
        case (code)
            WCNT_ONE: return slot;
            WCNT_TWO: return {slot[BEAT_W-1:1], 1'b0};
            default:  return '0;
        endcase
    endfunction

    function automatic logic [BEAT_W-1:0] wr_last_cnt(input wcnt_e code);
        case (code)
            WCNT_ONE: return BEAT_W'(0);
            WCNT_TWO: return BEAT_W'(1);
            default:  return BEAT_W'(LINE_BEATS - 1);
        endcase
    endfunction

endpackage

// File: rtl/lbe_fill_ctrl.sv
module lbe_fill_ctrl
    import lbe_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              ar_valid,
    input  logic              ar_ready,
    output logic [ADDR_W-1:0] ar_addr,
    output logic [7:0]        ar_len,
    output logic [2:0]        ar_size,
    output logic [1:0]        ar_burst,
    input  logic              r_valid,
    output logic              r_ready,
    input  logic [DATA_W-1:0] r_data,
    input  logic [1:0]        r_resp,
    output logic              beat_valid,
    output logic [BEAT_W-1:0] beat_idx,
    output logic [DATA_W-1:0] beat_data,
    output logic [1:0]        beat_resp,
    output logic              beat_last
);

    localparam int HI_W = ADDR_W - BYTE_W;
    localparam logic [BEAT_W-1:0] CNT_END = BEAT_W'(LINE_BEATS - 1);

    rd_state_e         state_q;
    logic [HI_W-1:0]   beat_addr_q;
    logic [BEAT_W-1:0] cnt_q;

    logic unused_low;
    assign unused_low = ^req_addr[BYTE_W-1:0];

    assign req_ready  = (state_q == RD_IDLE);
    assign ar_valid   = (state_q == RD_ADDR);
    assign ar_addr    = {beat_addr_q, {BYTE_W{1'b0}}};
    assign ar_len     = 8'(LINE_BEATS - 1);
    assign ar_size    = SIZE_BEAT;
    assign ar_burst   = BURST_WRAP;
    assign r_ready    = (state_q == RD_DATA);
    assign beat_valid = r_valid && r_ready;
    assign beat_idx   = beat_addr_q[BEAT_W-1:0] + cnt_q;
    assign beat_data  = r_data;
    assign beat_resp  = r_resp;
    assign beat_last  = (cnt_q == CNT_END);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= RD_IDLE;
            beat_addr_q <= '0;
            cnt_q       <= '0;
        end else begin
            case (state_q)
                RD_IDLE: if (req_valid) begin
                    beat_addr_q <= req_addr[ADDR_W-1:BYTE_W];
                    cnt_q       <= '0;
                    state_q     <= RD_ADDR;
                end
                RD_ADDR: if (ar_ready) state_q <= RD_DATA;
                RD_DATA: if (r_valid) begin
                    cnt_q <= cnt_q + 1'b1;
                    if (beat_last) state_q <= RD_IDLE;
                end
                default: state_q <= RD_IDLE;
            endcase
        end
    end

    assert_ar_shape_R1: assert property (@(posedge clk) disable iff (rst)
        ar_valid |-> (ar_burst == BURST_WRAP) && (ar_len == 8'd3) && (ar_size == SIZE_BEAT));

    assert_single_fill_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    assert_last_reopens_R3: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && beat_last) |=> req_ready && !r_ready);

    assert_ar_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (ar_valid && !ar_ready) |=> ar_valid && $stable(ar_addr));

endmodule

// File: rtl/lbe_evict_ctrl.sv
module lbe_evict_ctrl
    import lbe_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [1:0]         req_beats,
    input  logic [LINE_DW-1:0] req_line,
    input  logic [LINE_SW-1:0] req_strb,
    output logic               aw_valid,
    input  logic               aw_ready,
    output logic [ADDR_W-1:0]  aw_addr,
    output logic [7:0]         aw_len,
    output logic [2:0]         aw_size,
    output logic [1:0]         aw_burst,
    output logic               w_valid,
    input  logic               w_ready,
    output logic [DATA_W-1:0]  w_data,
    output logic [STRB_W-1:0]  w_strb,
    output logic               w_last,
    input  logic               b_valid,
    output logic               b_ready,
    input  logic [1:0]         b_resp,
    output logic               done,
    output logic [1:0]         done_resp
);

    localparam int TAG_W = ADDR_W - LINE_W;

    wr_state_e          state_q;
    logic [TAG_W-1:0]   tag_q;
    logic [BEAT_W-1:0]  first_q;
    logic [BEAT_W-1:0]  end_q;
    logic [BEAT_W-1:0]  cnt_q;
    logic [LINE_DW-1:0] line_q;
    logic [LINE_SW-1:0] strb_q;
    logic [BEAT_W-1:0]  slot;

    logic [DATA_W-1:0] slot_data [LINE_BEATS];
    logic [STRB_W-1:0] slot_strb [LINE_BEATS];

    logic unused_low;
    assign unused_low = ^req_addr[BYTE_W-1:0];

    for (genvar g = 0; g < LINE_BEATS; g++) begin : g_slot
        assign slot_data[g] = line_q[g*DATA_W +: DATA_W];
        assign slot_strb[g] = strb_q[g*STRB_W +: STRB_W];
    end

    assign slot      = first_q + cnt_q;
    assign req_ready = (state_q == WR_IDLE);
    assign aw_valid  = (state_q == WR_ADDR);
    assign aw_addr   = {tag_q, first_q, {BYTE_W{1'b0}}};
    assign aw_len    = {{(8-BEAT_W){1'b0}}, end_q};
    assign aw_size   = SIZE_BEAT;
    assign aw_burst  = BURST_INCR;
    assign w_valid   = (state_q == WR_DATA);
    assign w_data    = slot_data[slot];
    assign w_strb    = slot_strb[slot];
    assign w_last    = (cnt_q == end_q);
    assign b_ready   = (state_q == WR_RESP);
    assign done      = b_valid && b_ready;
    assign done_resp = b_resp;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WR_IDLE;
            tag_q   <= '0;
            first_q <= '0;
            end_q   <= '0;
            cnt_q   <= '0;
            line_q  <= '0;
            strb_q  <= '0;
        end else begin
            case (state_q)
                WR_IDLE: if (req_valid) begin
                    tag_q   <= req_addr[ADDR_W-1:LINE_W];
                    first_q <= wr_first_slot(req_addr[LINE_W-1:BYTE_W], wcnt_e'(req_beats));
                    end_q   <= wr_last_cnt(wcnt_e'(req_beats));
                    cnt_q   <= '0;
                    line_q  <= req_line;
                    strb_q  <= req_strb;
                    state_q <= WR_ADDR;
                end
                WR_ADDR: if (aw_ready) state_q <= WR_DATA;
                WR_DATA: if (w_ready) begin
                    if (w_last) state_q <= WR_RESP;
                    else        cnt_q   <= cnt_q + 1'b1;
                end
                WR_RESP: if (b_valid) state_q <= WR_IDLE;
                default: state_q <= WR_IDLE;
            endcase
        end
    end

    assert_not_fixed_R5: assert property (@(posedge clk) disable iff (rst)
        aw_valid |-> (aw_burst == BURST_INCR) && (aw_size == SIZE_BEAT));

    assert_no_cross_R6: assert property (@(posedge clk) disable iff (rst)
        aw_valid |-> (aw_len[7:2] == 6'd0) &&
                     (({1'b0, aw_addr[5:4]} + {1'b0, aw_len[1:0]}) <= 3'd3));

    assert_w_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (w_valid && !w_ready) |=> w_valid && $stable(w_data) && $stable(w_strb));

    assert_wlast_end_R7: assert property (@(posedge clk) disable iff (rst)
        (w_valid && w_ready && w_last) |=> !w_valid && b_ready);

    assert_single_evict_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    assert_aw_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (aw_valid && !aw_ready) |=> aw_valid && $stable(aw_addr) && $stable(aw_len));

endmodule

// File: rtl/line_burst_engine.sv
module line_burst_engine
    import lbe_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fill_req_valid,
    output logic               fill_req_ready,
    input  logic [ADDR_W-1:0]  fill_req_addr,
    output logic               ar_valid,
    input  logic               ar_ready,
    output logic [ADDR_W-1:0]  ar_addr,
    output logic [7:0]         ar_len,
    output logic [2:0]         ar_size,
    output logic [1:0]         ar_burst,
    input  logic               r_valid,
    output logic               r_ready,
    input  logic [DATA_W-1:0]  r_data,
    input  logic [1:0]         r_resp,
    output logic               fill_beat_valid,
    output logic [BEAT_W-1:0]  fill_beat_idx,
    output logic [DATA_W-1:0]  fill_beat_data,
    output logic [1:0]         fill_beat_resp,
    output logic               fill_beat_last,
    input  logic               evict_req_valid,
    output logic               evict_req_ready,
    input  logic [ADDR_W-1:0]  evict_req_addr,
    input  logic [1:0]         evict_req_beats,
    input  logic [LINE_DW-1:0] evict_req_line,
    input  logic [LINE_SW-1:0] evict_req_strb,
    output logic               aw_valid,
    input  logic               aw_ready,
    output logic [ADDR_W-1:0]  aw_addr,
    output logic [7:0]         aw_len,
    output logic [2:0]         aw_size,
    output logic [1:0]         aw_burst,
    output logic               w_valid,
    input  logic               w_ready,
    output logic [DATA_W-1:0]  w_data,
    output logic [STRB_W-1:0]  w_strb,
    output logic               w_last,
    input  logic               b_valid,
    output logic               b_ready,
    input  logic [1:0]         b_resp,
    output logic               evict_done,
    output logic [1:0]         evict_resp
);

    lbe_fill_ctrl #(.ADDR_W(ADDR_W)) u_fill (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (fill_req_valid),
        .req_ready  (fill_req_ready),
        .req_addr   (fill_req_addr),
        .ar_valid   (ar_valid),
        .ar_ready   (ar_ready),
        .ar_addr    (ar_addr),
        .ar_len     (ar_len),
        .ar_size    (ar_size),
        .ar_burst   (ar_burst),
        .r_valid    (r_valid),
        .r_ready    (r_ready),
        .r_data     (r_data),
        .r_resp     (r_resp),
        .beat_valid (fill_beat_valid),
        .beat_idx   (fill_beat_idx),
        .beat_data  (fill_beat_data),
        .beat_resp  (fill_beat_resp),
        .beat_last  (fill_beat_last)
    );

    lbe_evict_ctrl #(.ADDR_W(ADDR_W)) u_evict (
        .clk       (clk),
        .rst       (rst),
        .req_valid (evict_req_valid),
        .req_ready (evict_req_ready),
        .req_addr  (evict_req_addr),
        .req_beats (evict_req_beats),
        .req_line  (evict_req_line),
        .req_strb  (evict_req_strb),
        .aw_valid  (aw_valid),
        .aw_ready  (aw_ready),
        .aw_addr   (aw_addr),
        .aw_len    (aw_len),
        .aw_size   (aw_size),
        .aw_burst  (aw_burst),
        .w_valid   (w_valid),
        .w_ready   (w_ready),
        .w_data    (w_data),
        .w_strb    (w_strb),
        .w_last    (w_last),
        .b_valid   (b_valid),
        .b_ready   (b_ready),
        .b_resp    (b_resp),
        .done      (evict_done),
        .done_resp (evict_resp)
    );

endmodule

// File: tb/line_burst_engine_bench.sv
`timescale 1ns/1ps
module line_burst_engine_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic          fill_req_valid = 0;
    logic          fill_req_ready;
    logic [31:0]   fill_req_addr = 0;
    logic          ar_valid;
    logic          ar_ready = 0;
    logic [31:0]   ar_addr;
    logic [7:0]    ar_len;
    logic [2:0]    ar_size;
    logic [1:0]    ar_burst;
    logic          r_valid = 0;
    logic          r_ready;
    logic [127:0]  r_data = 0;
    logic [1:0]    r_resp = 0;
    logic          fill_beat_valid;
    logic [1:0]    fill_beat_idx;
    logic [127:0]  fill_beat_data;
    logic [1:0]    fill_beat_resp;
    logic          fill_beat_last;
    logic          evict_req_valid = 0;
    logic          evict_req_ready;
    logic [31:0]   evict_req_addr = 0;
    logic [1:0]    evict_req_beats = 0;
    logic [511:0]  evict_req_line = 0;
    logic [63:0]   evict_req_strb = 0;
    logic          aw_valid;
    logic          aw_ready = 0;
    logic [31:0]   aw_addr;
    logic [7:0]    aw_len;
    logic [2:0]    aw_size;
    logic [1:0]    aw_burst;
    logic          w_valid;
    logic          w_ready = 0;
    logic [127:0]  w_data;
    logic [15:0]   w_strb;
    logic          w_last;
    logic          b_valid = 0;
    logic          b_ready;
    logic [1:0]    b_resp = 0;
    logic          evict_done;
    logic [1:0]    evict_resp;

    line_burst_engine #(.ADDR_W(32)) u_line_burst_engine (.*);

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_fill(input logic [31:0] addr, input int ar_wait, input int r_gap);
        logic [1:0] crit;
        logic [127:0] pat;
        crit = addr[5:4];
        check(fill_req_ready == 1'b1, "R3 ready before fill", 128'(fill_req_ready), 128'd1);
        fill_req_valid = 1'b1;
        fill_req_addr  = addr;
        tick();
        fill_req_valid = 1'b0;
        #1;
        check(ar_valid == 1'b1, "R1 ar_valid", 128'(ar_valid), 128'd1);
        check(ar_addr == {addr[31:4], 4'b0}, "R1 ar_addr", 128'(ar_addr), 128'({addr[31:4], 4'b0}));
        check(ar_len == 8'd3 && ar_size == 3'b100 && ar_burst == 2'b10, "R1 ar shape",
              128'({ar_len, 1'b0, ar_size, 2'b0, ar_burst}), 128'({8'd3, 1'b0, 3'b100, 2'b0, 2'b10}));
        check(fill_req_ready == 1'b0 && r_ready == 1'b0, "R4 busy in address phase",
              128'({fill_req_ready, r_ready}), 128'd0);
        for (int d = 0; d < ar_wait; d++) begin
            tick();
            #1;
            check(ar_valid == 1'b1 && ar_addr == {addr[31:4], 4'b0}, "R9 ar held",
                  128'(ar_addr), 128'({addr[31:4], 4'b0}));
        end
        ar_ready = 1'b1;
        tick();
        ar_ready = 1'b0;
        #1;
        check(ar_valid == 1'b0, "R9 ar dropped after accept", 128'(ar_valid), 128'd0);
        for (int n = 0; n < 4; n++) begin
            for (int g = 0; g < r_gap; g++) begin
                #1;
                check(fill_beat_valid == 1'b0 && r_ready == 1'b1, "R2 idle data phase",
                      128'({fill_beat_valid, r_ready}), 128'b01);
                tick();
            end
            pat = {4{addr ^ (32'h1111_0000 * 32'(n + 1))}};
            r_valid = 1'b1;
            r_data  = pat;
            r_resp  = 2'(n);
            #1;
            check(r_ready == 1'b1 && fill_beat_valid == 1'b1, "R2 beat valid",
                  128'({r_ready, fill_beat_valid}), 128'b11);
            check(fill_beat_idx == 2'(crit + 2'(n)), "R2 beat index",
                  128'(fill_beat_idx), 128'(2'(crit + 2'(n))));
            check(fill_beat_data == pat && fill_beat_resp == 2'(n), "R2 beat payload",
                  fill_beat_data, pat);
            check(fill_beat_last == (n == 3), "R3 beat last", 128'(fill_beat_last), 128'(n == 3));
            check(fill_req_ready == 1'b0, "R4 no second fill", 128'(fill_req_ready), 128'd0);
            tick();
            r_valid = 1'b0;
        end
        #1;
        check(fill_req_ready == 1'b1 && r_ready == 1'b0, "R3 ready after last",
              128'({fill_req_ready, r_ready}), 128'b10);
    endtask

    task automatic do_evict(input logic [31:0] addr, input logic [1:0] code, input int smode,
                            input int aw_wait, input bit w_stall);
        int beats;
        logic [1:0] first;
        logic [31:0] exp_addr;
        logic [127:0] slot_d [4];
        logic [15:0]  slot_s [4];
        beats = (code == 2'b00) ? 1 : (code == 2'b01) ? 2 : 4;
        first = (code == 2'b00) ? addr[5:4] : (code == 2'b01) ? {addr[5], 1'b0} : 2'b00;
        exp_addr = {addr[31:6], first, 4'b0};
        for (int j = 0; j < 4; j++) begin
            slot_d[j] = {4{addr ^ (32'h0101_0101 * 32'(j + 3)) ^ 32'(code)}};
            slot_s[j] = (smode == 0) ? 16'hFFFF : (smode == 1) ? 16'h0000 : (16'hA5C3 ^ 16'(j));
            evict_req_line[j*128 +: 128] = slot_d[j];
            evict_req_strb[j*16 +: 16]   = slot_s[j];
        end
        check(evict_req_ready == 1'b1, "R8 ready before write", 128'(evict_req_ready), 128'd1);
        evict_req_valid = 1'b1;
        evict_req_addr  = addr;
        evict_req_beats = code;
        tick();
        evict_req_valid = 1'b0;
        evict_req_line  = '0;
        evict_req_strb  = '0;
        #1;
        check(aw_valid == 1'b1 && evict_req_ready == 1'b0, "R8 aw out, request closed",
              128'({aw_valid, evict_req_ready}), 128'b10);
        if (code[1]) begin
            check(aw_addr == exp_addr, "R5 line base", 128'(aw_addr), 128'(exp_addr));
            check(aw_len == 8'd3, "R5 aw_len", 128'(aw_len), 128'd3);
        end else begin
            check(aw_addr == exp_addr, "R6 partial address", 128'(aw_addr), 128'(exp_addr));
            check(aw_len == 8'(beats - 1), "R6 partial length", 128'(aw_len), 128'(beats - 1));
        end
        check(aw_burst == 2'b01 && aw_size == 3'b100, "R5 incr burst",
              128'({aw_burst, aw_size}), 128'({2'b01, 3'b100}));
        check(32'(aw_addr[5:4]) + 32'(aw_len) <= 3, "R6 no line crossing",
              128'(aw_addr[5:4]), 128'(exp_addr[5:4]));
        for (int d = 0; d < aw_wait; d++) begin
            tick();
            #1;
            check(aw_valid == 1'b1 && aw_addr == exp_addr && aw_len == 8'(beats - 1), "R9 aw held",
                  128'(aw_addr), 128'(exp_addr));
        end
        aw_ready = 1'b1;
        tick();
        aw_ready = 1'b0;
        for (int k = 0; k < beats; k++) begin
            if (w_stall && k == beats - 1) begin
                #1;
                check(w_valid == 1'b1 && w_data == slot_d[first + 2'(k)], "R7 held under stall",
                      w_data, slot_d[first + 2'(k)]);
                tick();
            end
            w_ready = 1'b1;
            #1;
            check(w_valid == 1'b1 && b_ready == 1'b0, "R8 no b_ready during data",
                  128'({w_valid, b_ready}), 128'b10);
            check(w_data == slot_d[first + 2'(k)], "R7 beat data", w_data, slot_d[first + 2'(k)]);
            check(w_strb == slot_s[first + 2'(k)], "R7 beat strobes",
                  128'(w_strb), 128'(slot_s[first + 2'(k)]));
            check(w_last == (k == beats - 1), "R7 w_last", 128'(w_last), 128'(k == beats - 1));
            tick();
            w_ready = 1'b0;
        end
        #1;
        check(w_valid == 1'b0 && b_ready == 1'b1 && evict_done == 1'b0, "R8 waiting for response",
              128'({w_valid, b_ready, evict_done}), 128'b010);
        check(evict_req_ready == 1'b0, "R8 still closed", 128'(evict_req_ready), 128'd0);
        tick();
        b_valid = 1'b1;
        b_resp  = code;
        #1;
        check(evict_done == 1'b1 && evict_resp == code, "R8 completion",
              128'({evict_done, evict_resp}), 128'({1'b1, code}));
        tick();
        b_valid = 1'b0;
        #1;
        check(evict_done == 1'b0 && evict_req_ready == 1'b1 && b_ready == 1'b0, "R8 reopened",
              128'({evict_done, evict_req_ready, b_ready}), 128'b010);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stimulus
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check(fill_req_ready && evict_req_ready, "R4 R8 reset ready",
              128'({fill_req_ready, evict_req_ready}), 128'b11);
        check(!ar_valid && !aw_valid && !w_valid, "R9 reset no address or data",
              128'({ar_valid, aw_valid, w_valid}), 128'd0);
        check(!r_ready && !b_ready && !fill_beat_valid && !evict_done, "R2 R8 reset quiet",
              128'({r_ready, b_ready, fill_beat_valid, evict_done}), 128'd0);
        @(negedge clk);
        for (int line = 0; line < 2; line++) begin
            for (int w = 0; w < 16; w++) begin
                do_fill(32'h8000_1000 + 32'(line) * 32'h0004_0040 + 32'(w * 4), w % 3, (w >> 2) % 2);
            end
        end
        for (int code = 0; code < 4; code++) begin
            for (int b = 0; b < 4; b++) begin
                for (int s = 0; s < 3; s++) begin
                    do_evict(32'h4000_2000 + 32'(code) * 32'h0000_0400 + 32'(b * 16) + 32'(s * 4),
                             2'(code), s, (b + s) % 3, (s == 2));
                end
            end
        end
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule